// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one memory request issued by a group of 32 lanes and reduces it to the smallest set of cache-line transactions. Each lane has an active bit and a byte address. All lanes share one access size of 4, 8 or 16 bytes. The block registers the request. It drops and flags any active lane whose address is not naturally aligned to the access size. It then walks the remaining lanes and emits one transaction for each distinct aligned 128-byte line that they touch.

Each transaction appears on a valid/ready output. It carries the line base address and a mask of every lane that the line serves. After the last line has been taken, the block pulses `done` for one cycle and returns to idle, where it can accept the next request. A warp doing contiguous, aligned word accesses costs one transaction. Shifting the same pattern off a line boundary, or striding it, costs more.

Top module: `warp_line_coalescer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `req_ready` is 1, `txn_valid` is 0, `done` is 0 and `err_lanes` is 0.
- R2: `txn_line` is the byte address of the served lanes with its low 7 bits forced to zero. Every lane set in `txn_lanes` has an address inside that 128-byte line.
- R3: Exactly one transaction is emitted for each distinct line touched by the aligned active lanes. When 32 active lanes access contiguous 4-byte words starting on a line boundary, exactly one transaction is emitted, and its mask holds all 32 lanes.
- R4: When the contiguous 4-byte pattern starts off a line boundary, two transactions are emitted. A strided pattern emits one transaction per line it spans, which can be three or more.
- R5: `req_size` is encoded as follows: 2'b00 means 4 bytes, 2'b01 means 8 bytes, and 2'b10 or 2'b11 means 16 bytes. An active lane whose address is not a multiple of the size sets its bit in `err_lanes` and appears in no transaction. `err_lanes` is updated on acceptance and held until the next acceptance.
- R6: Transactions come out in order of the lowest-numbered lane still pending. Each transaction's mask includes every pending lane in that line, and a lane is served only once.
- R7: An inactive lane contributes no line and no error bit. A request with no active or aligned lanes emits no transaction and raises `done` in the cycle after acceptance.
- R8: A request is accepted on a clock edge where both `req_valid` and `req_ready` are high, and `req_ready` is high only while the block is idle. Request inputs that change after acceptance have no effect on the transactions in flight.
- R9: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_line` and `txn_lanes` hold their values. A transaction is consumed on the edge where both signals are high.
- R10: `done` is high for one cycle, the cycle after the last transaction is consumed. `req_ready` is high in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Block is idle and takes a request |
| req_active | input | 32 | Per-lane active bits |
| req_addr | input | 1024 | Lane i byte address at bits [32*i+31 : 32*i] |
| req_size | input | 2 | Access size code (see R5) |
| txn_valid | output | 1 | A line transaction is offered |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_line | output | 32 | Line base address, low 7 bits zero |
| txn_lanes | output | 32 | Lanes served by this line |
| err_lanes | output | 32 | Active lanes dropped for misalignment |
| done | output | 1 | One-cycle pulse when the request is finished |

## Verification
The hardest situation to bring about from the ports combines three things: lanes sharing a line are scattered across the lane numbers, the lowest pending lane belongs to a line holding higher addresses, and downstream stalls in the middle of the sequence. In that situation the ordering, the mask merge and the hold behaviour all interact. The stimulus builds descending and interleaved address patterns and mixes misaligned lanes into them. It drives `txn_ready` from a pseudo-random stall pattern. It also keeps `req_valid` high with new inputs while a request is still being worked, so that a queued request and the scrambled inputs meet the busy block.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coal_state_e;

  localparam logic [1:0] SZ_4B  = 2'b00;
  localparam logic [1:0] SZ_8B  = 2'b01;

  // low address bits that must be zero for a naturally aligned access
  function automatic logic [3:0] align_mask(logic [1:0] code);
    case (code)
      SZ_4B:   align_mask = 4'b0011;
      SZ_8B:   align_mask = 4'b0111;
      default: align_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/coal_align_check.sv
module coal_align_check #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0]   active,
  input  logic [LANES*4-1:0] low_bits,
  input  logic [1:0]         size_code,
  output logic [LANES-1:0]   keep,
  output logic [LANES-1:0]   bad
);
  import coal_pkg::*;

  logic [3:0] amask;
  assign amask = align_mask(size_code);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic mis;
    assign mis    = |(low_bits[g*4 +: 4] & amask);
    assign keep[g] = active[g] & ~mis;
    assign bad[g]  = active[g] & mis;
  end

endmodule

// File: rtl/coal_line_pick.sv
module coal_line_pick #(
  parameter int LANES = 32,
  parameter int TAGW  = 25
) (
  input  logic [LANES-1:0]      pending,
  input  logic [LANES*TAGW-1:0] tags,
  output logic                  any,
  output logic [TAGW-1:0]       tag,
  output logic [LANES-1:0]      mask
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LW-1:0] sel;

  // lowest-numbered pending lane wins
  always_comb begin
    sel = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) sel = LW'(i);
    end
  end

  assign any = |pending;
  assign tag = tags[sel*TAGW +: TAGW];

  for (genvar g = 0; g < LANES; g++) begin : g_match
    assign mask[g] = pending[g] & (tags[g*TAGW +: TAGW] == tag);
  end

endmodule

// File: rtl/warp_line_coalescer.sv
module warp_line_coalescer #(
  parameter int LANES      = 32,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [LANES-1:0]      req_active,
  input  logic [LANES*AW-1:0]   req_addr,
  input  logic [1:0]            req_size,
  output logic                  txn_valid,
  input  logic                  txn_ready,
  output logic [AW-1:0]         txn_line,
  output logic [LANES-1:0]      txn_lanes,
  output logic [LANES-1:0]      err_lanes,
  output logic                  done
);
  import coal_pkg::*;

  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int TAGW     = AW - LINE_LSB;

  coal_state_e            state_q, state_d;
  logic [LANES-1:0]       pend_q, pend_d;
  logic [LANES-1:0]       err_q;
  logic [LANES*TAGW-1:0]  tag_q;
  logic [LANES*TAGW-1:0]  tag_in;
  logic [LANES*4-1:0]     low_in;
  logic [LANES-1:0]       keep_in, bad_in;
  logic                   accept, fire;
  logic                   pick_any;
  logic [TAGW-1:0]        pick_tag;
  logic [LANES-1:0]       pick_mask;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign low_in[g*4 +: 4]       = req_addr[g*AW +: 4];
    assign tag_in[g*TAGW +: TAGW] = req_addr[g*AW + LINE_LSB +: TAGW];
  end

  coal_align_check #(.LANES(LANES)) u_align (
    .active    (req_active),
    .low_bits  (low_in),
    .size_code (req_size),
    .keep      (keep_in),
    .bad       (bad_in)
  );

  coal_line_pick #(.LANES(LANES), .TAGW(TAGW)) u_pick (
    .pending (pend_q),
    .tags    (tag_q),
    .any     (pick_any),
    .tag     (pick_tag),
    .mask    (pick_mask)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign txn_valid = (state_q == ST_BUSY) & pick_any;
  assign done      = (state_q == ST_BUSY) & ~pick_any;
  assign fire      = txn_valid & txn_ready;
  assign txn_line  = {pick_tag, {LINE_LSB{1'b0}}};
  assign txn_lanes = pick_mask;
  assign err_lanes = err_q;

  // next state
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_BUSY;
          pend_d  = keep_in;
        end
      end
      default: begin
        if (!pick_any) state_d = ST_IDLE;
        else if (fire) pend_d = pend_q & ~pick_mask;
      end
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      if (accept) err_q <= bad_in;
    end
  end

  // line tags, captured only on acceptance (no reset needed)
  always_ff @(posedge clk) begin
    if (accept) tag_q <= tag_in;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_line) && $stable(txn_lanes));

  assert_err_disjoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_lanes & err_lanes) == '0);

  assert_lowest_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_lanes & pend_q & (~pend_q + 1'b1)) != '0) && ((txn_lanes & ~pend_q) == '0));

  assert_done_then_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready && !done);

  assert_busy_no_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(err_lanes));

  assert_served_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pend_q & $past(txn_lanes)) == '0);

endmodule

// File: tb/warp_line_coalescer_bench.sv
module warp_line_coalescer_bench;
  localparam int LANES = 32;
  localparam int AW    = 32;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               req_valid;
  logic               req_ready;
  logic [LANES-1:0]   req_active;
  logic [LANES*AW-1:0] req_addr;
  logic [1:0]         req_size;
  logic               txn_valid;
  logic               txn_ready;
  logic [AW-1:0]      txn_line;
  logic [LANES-1:0]   txn_lanes;
  logic [LANES-1:0]   err_lanes;
  logic               done;

  always #4 clk = ~clk;

  warp_line_coalescer u_warp_line_coalescer (
    .clk, .rst_n, .req_valid, .req_ready, .req_active, .req_addr, .req_size,
    .txn_valid, .txn_ready, .txn_line, .txn_lanes, .err_lanes, .done
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  int    stall_mode = 0;

  // reference model state
  bit               m_busy;
  int               m_idx;
  logic [AW-1:0]    m_line[$];
  logic [LANES-1:0] m_mask[$];
  logic [LANES-1:0] m_err;
  logic [AW-1:0]    a[LANES];

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  function automatic void model_accept();
    logic [AW-1:0] adr;
    logic [LANES-1:0] pend;
    int amod;
    amod = (req_size == 2'b00) ? 4 : (req_size == 2'b01) ? 8 : 16;
    pend = '0;
    m_err = '0;
    m_line.delete();
    m_mask.delete();
    for (int i = 0; i < LANES; i++) begin
      adr = req_addr[i*AW +: AW];
      if (req_active[i]) begin
        if ((adr % amod) != 0) m_err[i] = 1'b1;
        else pend[i] = 1'b1;
      end
    end
    while (pend != 0) begin
      int lo;
      logic [AW-1:0] ln;
      logic [LANES-1:0] mk;
      lo = 0;
      while (!pend[lo]) lo++;
      ln = req_addr[lo*AW +: AW] / 128 * 128;
      mk = '0;
      for (int j = 0; j < LANES; j++)
        if (pend[j] && (req_addr[j*AW +: AW] / 128 * 128) == ln) mk[j] = 1'b1;
      pend &= ~mk;
      m_line.push_back(ln);
      m_mask.push_back(mk);
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_idx = 0; m_err = '0;
    end else if (!m_busy) begin
      if (req_valid) begin
        model_accept();
        m_busy = 1; m_idx = 0;
      end
    end else if (m_idx < m_line.size()) begin
      if (txn_ready) m_idx++;
    end else begin
      m_busy = 0;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev, ed;
      ev = m_busy && (m_idx < m_line.size());
      ed = m_busy && (m_idx == m_line.size());
      check(req_ready == !m_busy, "req_ready", 64'(req_ready), 64'(!m_busy));
      check(txn_valid == ev, "txn_valid", 64'(txn_valid), 64'(ev));
      check(done == ed, "done", 64'(done), 64'(ed));
      check(err_lanes == m_err, "err_lanes", 64'(err_lanes), 64'(m_err));
      if (ev && txn_valid) begin
        check(txn_line == m_line[m_idx], "txn_line", 64'(txn_line), 64'(m_line[m_idx]));
        check(txn_lanes == m_mask[m_idx], "txn_lanes", 64'(txn_lanes), 64'(m_mask[m_idx]));
      end
      case (stall_mode)
        0: txn_ready <= 1'b1;
        1: txn_ready <= ($urandom % 3) != 0;
        default: txn_ready <= ($urandom % 4) == 0;
      endcase
    end
  end

  task automatic pack(input logic [LANES-1:0] act, input logic [1:0] sz);
    req_active = act;
    req_size   = sz;
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = a[i];
  endtask

  task automatic scramble();
    req_active = $urandom;
    req_size   = 2'($urandom);
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = $urandom;
  endtask

  task automatic issue(input logic [LANES-1:0] act, input logic [1:0] sz);
    @(negedge clk);
    pack(act, sz);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    scramble();
    while (m_busy) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; txn_ready = 1'b1;
    req_active = '0; req_addr = '0; req_size = 2'b00;
    #3;
    // R1: outputs during reset
    check(req_ready && !txn_valid && !done && err_lanes == '0, "reset outputs",
          {req_ready, txn_valid, done}, 64'b100);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R3: contiguous aligned words, one line
    cur_req = "R3";
    for (int i = 0; i < LANES; i++) a[i] = 32'h1000 + 4*i;
    issue('1, 2'b00);

    // R4: shifted contiguous, two lines; strides over 2 and 3 lines
    cur_req = "R4";
    for (int i = 0; i < LANES; i++) a[i] = 32'h1040 + 4*i;
    issue('1, 2'b00);
    for (int i = 0; i < LANES; i++) a[i] = 32'h2000 + 8*i;
    issue('1, 2'b00);
    for (int i = 0; i < LANES; i++) a[i] = 32'h3000 + 12*i;
    issue('1, 2'b00);

    // R2: high address bits and line base
    cur_req = "R2";
    for (int i = 0; i < LANES; i++) a[i] = 32'hFFFF_FF00 + 4*i + (i % 2) * 32'h80;
    issue('1, 2'b00);

    // R5: sizes and misaligned lanes
    cur_req = "R5";
    for (int i = 0; i < LANES; i++) a[i] = 32'h4000 + 8*i;
    issue('1, 2'b01);
    for (int i = 0; i < LANES; i++) a[i] = 32'h5000 + 16*i;
    issue('1, 2'b10);
    for (int i = 0; i < LANES; i++) a[i] = 32'h6000 + 8*i + ((i % 3 == 0) ? 4 : 0);
    issue('1, 2'b01);
    for (int i = 0; i < LANES; i++) a[i] = 32'h7000 + 8*i;
    issue('1, 2'b11);

    // R6: descending addresses, interleaved lines
    cur_req = "R6";
    for (int i = 0; i < LANES; i++) a[i] = 32'h8000 + 16*(31 - i);
    issue('1, 2'b10);
    for (int i = 0; i < LANES; i++) a[i] = 32'h9000 + 128*(i % 4) + 4*(i / 4);
    issue('1, 2'b00);

    // R7: partial and empty activity, all-misaligned
    cur_req = "R7";
    for (int i = 0; i < LANES; i++) a[i] = 32'hA000 + 64*i;
    issue(32'h0F0F_00F1, 2'b00);
    issue('0, 2'b00);
    for (int i = 0; i < LANES; i++) a[i] = 32'hB002 + 4*i;
    issue('1, 2'b00);

    // R9: backpressure on interleaved pattern
    cur_req = "R9";
    stall_mode = 2;
    for (int i = 0; i < LANES; i++) a[i] = 32'hC000 + 128*(i % 5) + 4*i;
    issue('1, 2'b00);
    stall_mode = 1;
    for (int i = 0; i < LANES; i++) a[i] = 32'hD000 + 16*(31 - i) + 4*(i % 2);
    issue('1, 2'b10);

    // R8: valid held high while busy with a second request
    cur_req = "R8";
    stall_mode = 1;
    @(negedge clk);
    for (int i = 0; i < LANES; i++) a[i] = 32'hE040 + 4*i;
    pack('1, 2'b00);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < LANES; i++) a[i] = 32'hF000 + 32*i;
    pack(32'hFFFF_0000, 2'b00);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    scramble();
    while (m_busy) @(negedge clk);

    // R10: done timing under random traffic
    cur_req = "R10";
    for (int n = 0; n < 40; n++) begin
      logic [AW-1:0] base;
      int sz;
      stall_mode = n % 3;
      base = ($urandom % 64) * 128;
      sz = $urandom % 4;
      for (int i = 0; i < LANES; i++) begin
        a[i] = base + ($urandom % 512);
        if (($urandom % 4) != 0) a[i] = a[i] & ~32'hF;
      end
      issue($urandom, 2'(sz));
    end

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule